// File: doc/BRIEF.md
# Reflected CRC-32 Digest Unit

This block computes a 32-bit cyclic redundancy digest over a byte stream that carries one protocol data unit per packet. Packets arrive on a byte-wide valid/ready stream with start and end markers. In transmit mode the payload passes through to an output stream, and the four digest bytes follow the last payload byte. In check mode the incoming packet already ends with its four digest bytes. The block reports pass or fail on a result strobe one cycle after the final byte is accepted.

The arithmetic follows the conventions of serial Ethernet-style links. Each byte enters least significant bit first, and bytes are taken in arrival order. The register is loaded with all ones when a packet starts. The value sent is the bitwise complement of the remainder. The generator polynomial is a parameter and defaults to the Castagnoli polynomial in reflected form (0x82F63B78). The register advances one byte per clock through eight unrolled shift/XOR steps. Because every packet start reseeds the register, a new packet may follow the previous one with no idle cycle.

Top module: `crcd_engine`

## Requirements
- R1: At every byte accepted with `in_sop`=1 the remainder register is first reloaded with all ones, so packets sent back to back with no idle cycle each get their own independent digest.
- R2: Within a byte, bit 0 is processed first. Bytes are processed in the order they are accepted. The polynomial defaults to 0x82F63B78 in reflected form. For 32 zero bytes the digest value is 0x8A9136AA.
- R3: In transmit mode the four digest bytes follow the last payload byte on `out_data`. They are taken from the complemented remainder, least significant byte first (for 32 zero bytes: AA, 36, 91, 8A). `out_last`=1 only on the fourth digest byte.
- R4: In transmit mode every payload byte appears on `out_data` unchanged and in order, before its digest.
- R5: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_last` hold their values. In transmit mode `in_ready` is 0 while the output slot is full and not being taken, and for the cycle after an end byte is accepted.
- R6: `mode_chk`=1 selects check mode. In that mode `chk_done` pulses for one cycle, exactly one cycle after the byte with `in_eop`=1 is accepted. `chk_err` can be 1 only together with `chk_done`. It is 1 exactly when the last four bytes, read least significant byte first, differ from the complemented remainder of the bytes before them.
- R7: A packet checked with one extra zero byte in front of the payload fails the check. So does a packet with one extra zero byte between the payload and its digest.
- R8: After the synchronous active-high reset, `out_valid`, `chk_done` and `chk_err` are 0 and `in_ready` is 1.
- R9: In check mode `in_ready` is always 1 and `out_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_chk | input | 1 | 0 = transmit (append digest), 1 = check |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take the input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| out_valid | output | 1 | Output byte valid (transmit mode) |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Payload or digest byte |
| out_last | output | 1 | Final digest byte of a packet |
| chk_done | output | 1 | Check result strobe |
| chk_err | output | 1 | Digest mismatch, qualified by `chk_done` |

## Verification
The assertions rely on a few properties of the input stream:
- `mode_chk` changes only between packets, after the output stream has drained.
- Every packet starts with `in_sop` and ends with `in_eop`.
- In check mode, every packet is at least four bytes long.

The bench meets these conditions. It changes mode only after a stream has fully completed, including drain cycles, and builds every packet with its start and end markers set. Output backpressure is applied only in transmit mode, through a periodic stall pattern on `out_ready`.

// File: rtl/crcd_pkg.sv
package crcd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    EMIT_PAYLOAD = 1'b0,
    EMIT_DIGEST  = 1'b1
  } emit_state_t;
endpackage

// File: rtl/crcd_byte_step.sv
// One byte of reflected CRC update: eight unrolled shift/XOR steps, bit 0 first.
module crcd_byte_step #(
  parameter int unsigned           CRC_W = 32,
  parameter logic [CRC_W-1:0]      POLY  = 32'h82F63B78
) (
  input  logic [CRC_W-1:0]          crc_in,
  input  logic [crcd_pkg::BYTE_W-1:0] data_in,
  output logic [CRC_W-1:0]          crc_out
);
  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = crc_in;
    for (int i = 0; i < int'(crcd_pkg::BYTE_W); i++) begin
      if (acc[0] ^ data_in[i]) acc = (acc >> 1) ^ POLY;
      else                     acc = acc >> 1;
    end
    crc_out = acc;
  end
endmodule

// File: rtl/crcd_state.sv
// Remainder register with reseed on packet start.
module crcd_state #(
  parameter int unsigned      CRC_W = 32,
  parameter logic [CRC_W-1:0] POLY  = 32'h82F63B78,
  parameter logic [CRC_W-1:0] SEED  = '1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          restart,
  input  logic [crcd_pkg::BYTE_W-1:0]   data,
  output logic [CRC_W-1:0]              crc_nxt
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = restart ? SEED : crc_q;

  crcd_byte_step #(.CRC_W(CRC_W), .POLY(POLY)) step_i (
    .crc_in  (base),
    .data_in (data),
    .crc_out (crc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       crc_q <= SEED;
    else if (load) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/crcd_emitter.sv
// Transmit output register: passes payload, then serialises the digest LSB byte first.
module crcd_emitter #(
  parameter int unsigned CRC_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tx_en,
  input  logic                        in_fire,
  input  logic                        in_last,
  input  logic [crcd_pkg::BYTE_W-1:0] in_data,
  input  logic [CRC_W-1:0]            digest,
  output logic                        take_ok,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [crcd_pkg::BYTE_W-1:0] out_data,
  output logic                        out_last
);
  import crcd_pkg::*;
  localparam int unsigned NB = CRC_W / BYTE_W;
  localparam int unsigned CW = (NB > 1) ? $clog2(NB) : 1;

  emit_state_t          state_q;
  logic [CW-1:0]        cnt_q;
  logic [CRC_W-1:0]     dig_q;
  logic [BYTE_W-1:0]    lane [NB];
  logic                 slot_free;
  logic                 final_lane;

  for (genvar k = 0; k < int'(NB); k++) begin : g_lane
    assign lane[k] = dig_q[k*BYTE_W +: BYTE_W];
  end

  assign slot_free  = !out_valid || out_ready;
  assign take_ok    = (state_q == EMIT_PAYLOAD) && slot_free;
  assign final_lane = (cnt_q == CW'(NB - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= EMIT_PAYLOAD;
      cnt_q     <= '0;
      dig_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      case (state_q)
        EMIT_PAYLOAD: begin
          if (in_fire && tx_en) begin
            out_data  <= in_data;
            out_valid <= 1'b1;
            out_last  <= 1'b0;
            if (in_last) begin
              state_q <= EMIT_DIGEST;
              dig_q   <= digest;
              cnt_q   <= '0;
            end
          end else if (out_ready) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
          end
        end
        EMIT_DIGEST: begin
          if (slot_free) begin
            out_data  <= lane[cnt_q];
            out_valid <= 1'b1;
            out_last  <= final_lane;
            cnt_q     <= cnt_q + 1'b1;
            if (final_lane) state_q <= EMIT_PAYLOAD;
          end
        end
        default: state_q <= EMIT_PAYLOAD;
      endcase
    end
  end
endmodule

// File: rtl/crcd_verify.sv
// Check-mode result: compares the post-digest remainder with the fixed residue.
module crcd_verify #(
  parameter int unsigned      CRC_W   = 32,
  parameter logic [CRC_W-1:0] RESIDUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_en,
  input  logic             fire_last,
  input  logic [CRC_W-1:0] crc_nxt,
  output logic             done,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= fire_last && chk_en;
      err  <= fire_last && chk_en && (crc_nxt != RESIDUE);
    end
  end
endmodule

// File: rtl/crcd_engine.sv
module crcd_engine #(
  parameter int unsigned                 CRC_W = 32,
  parameter logic [CRC_W-1:0]            POLY  = 32'h82F63B78,
  parameter logic [CRC_W-1:0]            SEED  = '1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_chk,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       chk_done,
  output logic       chk_err
);
  import crcd_pkg::*;
  localparam int unsigned NB = CRC_W / BYTE_W;

  // Remainder left after a packet plus its own complemented digest; data independent.
  function automatic logic [CRC_W-1:0] calc_residue();
    logic [CRC_W-1:0] c;
    logic [CRC_W-1:0] d;
    c = SEED;
    d = ~SEED;
    for (int k = 0; k < int'(NB * BYTE_W); k++) begin
      if (c[0] ^ d[k]) c = (c >> 1) ^ POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

  localparam logic [CRC_W-1:0] RESIDUE = calc_residue();

  logic             fire;
  logic             take_ok;
  logic [CRC_W-1:0] crc_nxt;

  assign in_ready = mode_chk ? 1'b1 : take_ok;
  assign fire     = in_valid && in_ready;

  crcd_state #(.CRC_W(CRC_W), .POLY(POLY), .SEED(SEED)) state_i (
    .clk     (clk),
    .rst     (rst),
    .load    (fire),
    .restart (in_sop),
    .data    (in_data),
    .crc_nxt (crc_nxt)
  );

  crcd_emitter #(.CRC_W(CRC_W)) emit_i (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (!mode_chk),
    .in_fire   (fire),
    .in_last   (in_eop),
    .in_data   (in_data),
    .digest    (~crc_nxt),
    .take_ok   (take_ok),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
  );

  crcd_verify #(.CRC_W(CRC_W), .RESIDUE(RESIDUE)) verify_i (
    .clk       (clk),
    .rst       (rst),
    .chk_en    (mode_chk),
    .fire_last (fire && in_eop),
    .crc_nxt   (crc_nxt),
    .done      (chk_done),
    .err       (chk_err)
  );
endmodule

// File: rtl/crcd_engine_chk.sv
module crcd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       mode_chk,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_eop,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       chk_done,
  input logic       chk_err
);
  logic end_taken;
  assign end_taken = in_valid && in_ready && in_eop;

  assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !chk_done && !chk_err && in_ready));

  assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_digest_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (!mode_chk && end_taken) |=> !in_ready);

  assert_last_valid_R3: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  assert_done_timing_R6: assert property (@(posedge clk) disable iff (rst)
    (mode_chk && end_taken) |=> chk_done);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (rst)
    chk_done |-> $past(mode_chk && end_taken));

  assert_err_qual_R6: assert property (@(posedge clk) disable iff (rst)
    chk_err |-> chk_done);

  assert_chk_stream_R9: assert property (@(posedge clk) disable iff (rst)
    mode_chk |-> (in_ready && !out_valid));
endmodule

bind crcd_engine crcd_engine_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode_chk  (mode_chk),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .chk_done  (chk_done),
  .chk_err   (chk_err)
);

// File: tb/crcd_engine_tb_top.sv
`timescale 1ns/1ps
module crcd_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_chk = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0;
  logic       in_eop = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       chk_done;
  logic       chk_err;

  always #4 clk = ~clk;

  crcd_engine dut_i (.*);

  int checks = 0;
  int fails  = 0;

  logic [7:0] sbuf [0:511];
  logic       ssop [0:511];
  logic       seop [0:511];
  int         sn;
  logic [7:0] ebuf [0:511];
  logic       elast[0:511];
  int         en;
  logic       eerr [0:15];
  int         ndone;
  logic [7:0] obuf [0:511];
  logic       olast[0:511];
  int         on;
  logic       derr [0:15];
  int         dn;

  // vector: {chk, stall, mut[1:0], kind[1:0], len[5:0]}
  localparam int NV = 12;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 2'd0, 2'd0, 6'd32},
    {1'b0, 1'b1, 2'd0, 2'd2, 6'd17},
    {1'b0, 1'b1, 2'd0, 2'd1, 6'd1},
    {1'b0, 1'b0, 2'd0, 2'd3, 6'd63},
    {1'b1, 1'b0, 2'd0, 2'd2, 6'd20},
    {1'b1, 1'b0, 2'd1, 2'd2, 6'd20},
    {1'b1, 1'b0, 2'd2, 2'd2, 6'd20},
    {1'b1, 1'b0, 2'd3, 2'd2, 6'd20},
    {1'b1, 1'b0, 2'd2, 2'd0, 6'd32},
    {1'b1, 1'b0, 2'd3, 2'd0, 6'd32},
    {1'b1, 1'b0, 2'd0, 2'd3, 6'd5},
    {1'b1, 1'b0, 2'd1, 2'd1, 6'd9}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int kind, input int i);
    case (kind)
      0:       return 8'h00;
      1:       return 8'hFF;
      2:       return 8'(i);
      default: return 8'hA5 ^ 8'(i * 7);
    endcase
  endfunction

  // Bit-serial model in normal form: LSB of each byte first into an MSB-first register.
  function automatic logic [31:0] model(input int s, input int len);
    logic [31:0] c;
    logic [31:0] r;
    c = 32'hFFFFFFFF;
    for (int k = 0; k < len; k++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[31] ^ sbuf[s+k][b];
        c = {c[30:0], 1'b0} ^ (fb ? 32'h1EDC6F41 : 32'h0);
      end
    end
    for (int b = 0; b < 32; b++) r[b] = c[31-b];
    return ~r;
  endfunction

  task automatic add_pkt(input bit chk, input int mut, input int kind, input int len);
    int s;
    int pl;
    logic [31:0] d;
    logic [31:0] got;
    s = sn;
    for (int i = 0; i < len; i++) sbuf[s+i] = pat(kind, i);
    d = model(s, len);
    if (!chk) begin
      for (int i = 0; i < len; i++) begin ebuf[en] = sbuf[s+i]; elast[en] = 1'b0; en++; end
      for (int k = 0; k < 4; k++) begin ebuf[en] = d[8*k +: 8]; elast[en] = (k == 3); en++; end
      sn = s + len;
    end else begin
      pl = len;
      if (mut == 2) begin
        for (int i = len - 1; i >= 0; i--) sbuf[s+i+1] = sbuf[s+i];
        sbuf[s] = 8'h00;
        pl = len + 1;
      end else if (mut == 3) begin
        sbuf[s+len] = 8'h00;
        pl = len + 1;
      end
      if (mut == 1) d = d ^ 32'h0001_0000;
      for (int k = 0; k < 4; k++) sbuf[s+pl+k] = d[8*k +: 8];
      sn = s + pl + 4;
      got = {sbuf[s+pl+3], sbuf[s+pl+2], sbuf[s+pl+1], sbuf[s+pl]};
      eerr[ndone] = (model(s, pl) != got);
      ndone++;
    end
    for (int i = s; i < sn; i++) begin ssop[i] = (i == s); seop[i] = (i == sn - 1); end
  endtask

  task automatic run_stream(input bit chk, input bit stall);
    int p;
    int guard;
    p = 0; guard = 0; on = 0; dn = 0;
    @(negedge clk);
    mode_chk = chk;
    while ((p < sn || (!chk && on < en)) && guard < 3000) begin
      @(negedge clk);
      out_ready = stall ? ((guard % 3) != 1) : 1'b1;
      if (p < sn) begin
        in_valid = 1'b1; in_data = sbuf[p]; in_sop = ssop[p]; in_eop = seop[p];
      end else begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
      #1;
      if (chk_done && dn < 16) begin derr[dn] = chk_err; dn++; end
      if (out_valid && out_ready && on < 512) begin obuf[on] = out_data; olast[on] = out_last; on++; end
      if (in_valid && in_ready) p++;
      guard++;
    end
    check(guard < 3000, "stream progress", 32'(guard), 32'd3000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; out_ready = 1'b1;
      #1;
      if (chk_done && dn < 16) begin derr[dn] = chk_err; dn++; end
      if (out_valid && out_ready && on < 512) begin obuf[on] = out_data; olast[on] = out_last; on++; end
    end
  endtask

  task automatic check_tx();
    int bad;
    int lbad;
    bad = 0; lbad = 0;
    check(on == en, "R4 output byte count", 32'(on), 32'(en));
    for (int i = 0; i < en && i < on; i++) begin
      if (obuf[i] != ebuf[i]) begin
        if (bad == 0) $display("FAIL R3/R4 byte %0d: actual %h expected %h", i, obuf[i], ebuf[i]);
        bad++;
      end
      if (olast[i] != elast[i]) lbad++;
    end
    checks++;
    if (bad != 0) fails++;
    check(lbad == 0, "R3 out_last placement", 32'(lbad), 32'd0);
  endtask

  task automatic check_rx();
    check(dn == ndone, "R6 chk_done pulses", 32'(dn), 32'(ndone));
    for (int i = 0; i < ndone && i < dn; i++)
      check(derr[i] == eerr[i], "R6/R7 chk_err", 32'(derr[i]), 32'(eerr[i]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(!out_valid && !chk_done && !chk_err && in_ready, "R8 reset state",
          {out_valid, chk_done, chk_err, in_ready}, 32'b0001);

    // R2: model sanity against the published zero-vector digest
    for (int i = 0; i < 32; i++) sbuf[i] = 8'h00;
    check(model(0, 32) == 32'h8A9136AA, "R2 model zero vector", model(0, 32), 32'h8A9136AA);

    // table walk
    for (int v = 0; v < NV; v++) begin
      sn = 0; en = 0; ndone = 0;
      add_pkt(VEC[v][11], int'(VEC[v][9:8]), int'(VEC[v][7:6]), int'(VEC[v][5:0]));
      run_stream(VEC[v][11], VEC[v][10]);
      if (VEC[v][11]) check_rx(); else check_tx();
    end

    // R2/R3 directed: 32 zero bytes give AA 36 91 8A, last byte flagged
    sn = 0; en = 0; ndone = 0;
    add_pkt(1'b0, 0, 0, 32);
    run_stream(1'b0, 1'b1);
    check(on == 36 && {obuf[35], obuf[34], obuf[33], obuf[32]} == 32'h8A9136AA,
          "R2 zero-vector digest", {obuf[35], obuf[34], obuf[33], obuf[32]}, 32'h8A9136AA);
    check(on == 36 && olast[35] && !olast[34], "R3 last flag on 4th digest byte",
          32'(olast[35]), 32'd1);

    // R1: back-to-back transmit packets
    sn = 0; en = 0; ndone = 0;
    add_pkt(1'b0, 0, 2, 6);
    add_pkt(1'b0, 0, 3, 6);
    add_pkt(1'b0, 0, 1, 3);
    run_stream(1'b0, 1'b0);
    check_tx();

    // R1/R9: back-to-back check packets with no idle cycle, mixed pass/fail
    sn = 0; en = 0; ndone = 0;
    add_pkt(1'b1, 0, 2, 8);
    add_pkt(1'b1, 1, 3, 4);
    add_pkt(1'b1, 0, 0, 12);
    add_pkt(1'b1, 2, 1, 7);
    run_stream(1'b1, 1'b0);
    check_rx();
    check(!out_valid && in_ready, "R9 check-mode stream idle", {out_valid, in_ready}, 32'b01);

    // R8: reset in mid-stream returns to idle
    @(negedge clk);
    mode_chk = 1'b0; in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h3C; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b1;
    #1;
    check(!out_valid && !chk_done && !chk_err && in_ready, "R8 reset mid-stream",
          {out_valid, chk_done, chk_err, in_ready}, 32'b0001);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule